// File: doc/BRIEF.md
# SPI Slave Byte Engine with Underflow and Overflow Flags

This block is the serial side of a four-wire SPI target. An external host drives SCK, MOSI and an active-low chip select. The block moves whole bytes between that serial stream and two first-word-fall-through FIFOs that sit outside it. Bytes to send come from the transmit FIFO through a valid/pop handshake. Received bytes go to the receive FIFO through a space/push handshake. Each direction has its own enable. The block has no storage of its own beyond one shift register per direction.

The three serial inputs pass through a two-flop synchronizer into the system clock domain. The block then works out which SCK transitions shift data out and which ones sample data in. This depends on the programmed clock polarity and phase. Bit order is selectable. When a byte cannot be served, the block records it in one of two sticky error flags. A transmit byte with nothing queued sets the underflow flag, and a received byte with no room sets the overflow flag. Software clears each flag by writing a one to its clear input.

Top module: `spi_slave_port`

## Requirements
- R1: A byte carries FIFO data only when `tx_en_i` is high and `tx_valid_i` is high at the start of the byte. That byte is popped exactly once, with a one-cycle `tx_pop_o`, at the first SCK edge of the byte. In every other case MISO shifts out all ones and nothing is popped.
- R2: If `tx_en_i` is high and a byte's first SCK edge arrives with no transmit data available, `underflow_o` is set.
- R3: After the eighth sampled bit of a byte, a one-cycle `rx_push_o` is issued with the assembled byte on `rx_data_o`. This happens only when `rx_en_i` and `rx_space_i` are both high. With `rx_en_i` low the byte is dropped and no flag is raised.
- R4: If `rx_en_i` is high and `rx_space_i` is low when the eighth bit is sampled, the byte is discarded with no push, and `overflow_o` is set.
- R5: The idle level of SCK equals `cpol_i`. The leading edge is the transition away from the idle level. With `cpha_i`=0, bits are sampled on leading edges and driven on trailing edges, and the first bit is driven after chip select asserts. With `cpha_i`=1, bits are driven on leading edges and sampled on trailing edges. `lsb_first_i`=1 sends and receives bit 0 first; otherwise bit 7 goes first.
- R6: Both error flags stay set until a cycle with the matching clear input high. A new set event in the same cycle as a clear keeps the flag set.
- R7: Raising chip select in mid-byte discards the partial byte with no push. It resets the bit count, so the next selection starts a fresh byte.
- R8: SCK, MOSI and chip select are synchronized with two flops, and the system clock must run at least 4 times the SCK rate. Chip select asserting and deasserting with no SCK edge pops nothing and flags nothing.
- R9: `miso_oe_o` is low while chip select is deasserted and high while it is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | SCK idle level |
| cpha_i | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsb_first_i | input | 1 | 1: bit 0 first; 0: bit 7 first |
| tx_en_i | input | 1 | Transmit path enable |
| rx_en_i | input | 1 | Receive path enable |
| sck_i | input | 1 | Serial clock from host (asynchronous) |
| csn_i | input | 1 | Active-low chip select from host (asynchronous) |
| mosi_i | input | 1 | Serial data from host (asynchronous) |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Output enable for the MISO pad driver |
| tx_data_i | input | DW | Head entry of the transmit FIFO |
| tx_valid_i | input | 1 | Transmit FIFO not empty |
| tx_pop_o | output | 1 | One-cycle pop of the transmit FIFO |
| rx_data_o | output | DW | Byte to write into the receive FIFO |
| rx_push_o | output | 1 | One-cycle push into the receive FIFO |
| rx_space_i | input | 1 | Receive FIFO not full |
| underflow_o | output | 1 | Sticky transmit underflow flag |
| overflow_o | output | 1 | Sticky receive overflow flag |
| clr_underflow_i | input | 1 | Write-one-to-clear for underflow |
| clr_overflow_i | input | 1 | Write-one-to-clear for overflow |

## Verification
The bench runs all eight combinations of polarity, phase and bit order with known byte pairs. A wrong edge choice or a reversed shift would show up as rotated or bit-reversed bytes on either line. It runs out of transmit data in the middle of a frame, disables the transmit path while data is queued, and starves the receive FIFO. A design that popped too early, popped while disabled, or pushed into a full FIFO would leave the model FIFO pointers in the wrong place, or show real data where all ones belong. It also raises chip select after four bits and opens a selection with no clock edges. A design that kept a stale bit count would mangle the following byte, and one that popped on selection alone would lose a queued byte.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
  typedef struct packed {
    logic smp;      // sample MOSI
    logic shf;      // advance MISO
    logic sel_fall; // chip select just asserted
  } spi_evt_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s - 1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi_edge_gen.sv
module spi_edge_gen
  import spi_slave_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sck_s_i,
  input  logic     csn_s_i,
  input  logic     cpol_i,
  input  logic     cpha_i,
  output spi_evt_t evt_o
);
  logic sck_d, csn_d;
  logic toggled, lead, trail, sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_d <= sck_s_i;
      csn_d <= csn_s_i;
    end
  end

  always_comb begin
    sel     = !csn_s_i;
    toggled = sck_s_i != sck_d;
    lead    = toggled && (sck_s_i != cpol_i);
    trail   = toggled && (sck_s_i == cpol_i);
    evt_o.smp      = sel && (cpha_i ? trail : lead);
    evt_o.shf      = sel && (cpha_i ? lead : trail);
    evt_o.sel_fall = csn_d && !csn_s_i;
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine
  import spi_slave_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  spi_evt_t      evt_i,
  input  logic          csn_s_i,
  input  logic          mosi_s_i,
  input  logic          cpha_i,
  input  logic          lsb_first_i,
  input  logic          tx_en_i,
  input  logic          rx_en_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  input  logic          rx_space_i,
  output logic          miso_o,
  output logic          tx_pop_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_push_o,
  output logic          ufl_set_o,
  output logic          ofl_set_o
);
  localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [CW-1:0] bit_cnt;
  logic          open_q;     // first edge of current byte seen
  logic          pre_real_q; // previewed byte holds FIFO data
  logic [DW-1:0] tx_sr, rx_sr, rx_q;
  logic          push_q;

  logic          load_real, do_load, commit, commit_real, last, push_ok;
  logic [DW-1:0] load_val, rx_next, tx_shifted;

  always_comb begin
    load_real   = tx_en_i && tx_valid_i;
    load_val    = load_real ? tx_data_i : '1;
    // phase 0 previews the byte before its first edge; phase 1 loads on it
    do_load     = (evt_i.sel_fall && !cpha_i) || (evt_i.shf && !open_q);
    commit      = !open_q && (cpha_i ? evt_i.shf : evt_i.smp);
    commit_real = cpha_i ? load_real : (pre_real_q && load_real);
    tx_pop_o    = commit && commit_real;
    ufl_set_o   = commit && tx_en_i && !commit_real;
    last        = evt_i.smp && (bit_cnt == LAST_BIT);
    rx_next     = lsb_first_i ? {mosi_s_i, rx_sr[DW-1:1]} : {rx_sr[DW-2:0], mosi_s_i};
    push_ok     = last && rx_en_i && rx_space_i;
    ofl_set_o   = last && rx_en_i && !rx_space_i;
    tx_shifted  = lsb_first_i ? {1'b1, tx_sr[DW-1:1]} : {tx_sr[DW-2:0], 1'b1};
    miso_o      = lsb_first_i ? tx_sr[0] : tx_sr[DW-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt    <= '0;
      open_q     <= 1'b0;
      pre_real_q <= 1'b0;
      tx_sr      <= '1;
      rx_sr      <= '0;
      rx_q       <= '0;
      push_q     <= 1'b0;
    end else begin
      push_q <= push_ok;
      if (push_ok) rx_q <= rx_next;
      if (csn_s_i) begin
        bit_cnt <= '0;
        open_q  <= 1'b0;
      end else begin
        if (evt_i.smp) begin
          rx_sr   <= rx_next;
          bit_cnt <= last ? '0 : bit_cnt + 1'b1;
        end
        if (last) open_q <= 1'b0;
        else if (commit) open_q <= 1'b1;
        if (do_load) begin
          tx_sr      <= load_val;
          pre_real_q <= load_real;
        end else if (evt_i.shf && open_q) begin
          tx_sr <= tx_shifted;
        end
      end
    end
  end

  assign rx_data_o = rx_q;
  assign rx_push_o = push_q;
endmodule

// File: rtl/spi_err_flags.sv
module spi_err_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1; // set beats clear
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port
  import spi_slave_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpol_i,
  input  logic          cpha_i,
  input  logic          lsb_first_i,
  input  logic          tx_en_i,
  input  logic          rx_en_i,
  input  logic          sck_i,
  input  logic          csn_i,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_valid_i,
  output logic          tx_pop_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_push_o,
  input  logic          rx_space_i,
  output logic          underflow_o,
  output logic          overflow_o,
  input  logic          clr_underflow_i,
  input  logic          clr_overflow_i
);
  localparam int unsigned NSYNC = 3;
  localparam int unsigned NFLAG = 2;

  logic [NSYNC-1:0] pins_s;
  logic             sck_s, csn_s, mosi_s;
  spi_evt_t         evt;
  logic             ufl_set, ofl_set;
  logic [NFLAG-1:0] flags;

  // bit order {csn, sck, mosi}; chip select resets deasserted
  spi_in_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({csn_i, sck_i, mosi_i}),
    .q_o (pins_s)
  );
  assign {csn_s, sck_s, mosi_s} = pins_s;

  spi_edge_gen u_edge (
    .clk_i, .rst_ni,
    .sck_s_i (sck_s),
    .csn_s_i (csn_s),
    .cpol_i, .cpha_i,
    .evt_o   (evt)
  );

  spi_byte_engine #(.DW(DW)) u_eng (
    .clk_i, .rst_ni,
    .evt_i     (evt),
    .csn_s_i   (csn_s),
    .mosi_s_i  (mosi_s),
    .cpha_i, .lsb_first_i, .tx_en_i, .rx_en_i,
    .tx_data_i, .tx_valid_i, .rx_space_i,
    .miso_o, .tx_pop_o, .rx_data_o, .rx_push_o,
    .ufl_set_o (ufl_set),
    .ofl_set_o (ofl_set)
  );

  spi_err_flags #(.N(NFLAG)) u_err (
    .clk_i, .rst_ni,
    .set_i  ({ofl_set, ufl_set}),
    .clr_i  ({clr_overflow_i, clr_underflow_i}),
    .flag_o (flags)
  );

  assign {overflow_o, underflow_o} = flags;
  assign miso_oe_o = !csn_s;
endmodule

// File: rtl/spi_slave_port_chk.sv
module spi_slave_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic csn_s,
  input logic tx_en_i,
  input logic tx_valid_i,
  input logic tx_pop_o,
  input logic rx_en_i,
  input logic rx_space_i,
  input logic rx_push_o,
  input logic underflow_o,
  input logic overflow_o,
  input logic clr_underflow_i,
  input logic clr_overflow_i,
  input logic miso_oe_o
);
  AST_POP_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> (tx_en_i && tx_valid_i)); // R1
  AST_POP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |=> !tx_pop_o); // R1
  AST_UFL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underflow_o) |-> $past(tx_en_i && !tx_pop_o)); // R2
  AST_PUSH_NEEDS_SPACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> $past(rx_en_i && rx_space_i)); // R3
  AST_PUSH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |=> !rx_push_o); // R3
  AST_OFL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> $past(rx_en_i && !rx_space_i)); // R4
  AST_NO_OVERFLOW_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overflow_o) |-> !rx_push_o); // R4
  AST_UFL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !clr_underflow_i) |=> underflow_o); // R6
  AST_OFL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o && !clr_overflow_i) |=> overflow_o); // R6
  AST_IDLE_NO_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_s |-> !tx_pop_o); // R7
  AST_POP_WHILE_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop_o |-> miso_oe_o); // R9
endmodule

bind spi_slave_port spi_slave_port_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .csn_s           (csn_s),
  .tx_en_i         (tx_en_i),
  .tx_valid_i      (tx_valid_i),
  .tx_pop_o        (tx_pop_o),
  .rx_en_i         (rx_en_i),
  .rx_space_i      (rx_space_i),
  .rx_push_o       (rx_push_o),
  .underflow_o     (underflow_o),
  .overflow_o      (overflow_o),
  .clr_underflow_i (clr_underflow_i),
  .clr_overflow_i  (clr_overflow_i),
  .miso_oe_o       (miso_oe_o)
);

// File: tb/spi_slave_port_tb.sv
module spi_slave_port_tb;
  localparam int H = 8; // SCK half period in clk cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cpol = 0, cpha = 0, lsb = 0, tx_en = 1, rx_en = 1;
  logic sck = 0, csn = 1, mosi = 0;
  logic miso, miso_oe, tx_pop, rx_push, ufl, ofl;
  logic rx_space = 1, clr_u = 0, clr_o = 0;
  logic [7:0] rx_data;

  logic [7:0] tx_mem [64];
  logic [7:0] rx_mem [64];
  logic [5:0] tx_wr = '0, tx_rd, rx_wr;
  logic tx_valid;
  logic [7:0] tx_data;
  assign tx_valid = tx_rd != tx_wr;
  assign tx_data  = tx_mem[tx_rd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_rd <= '0;
      rx_wr <= '0;
    end else begin
      if (tx_pop) tx_rd <= tx_rd + 1'b1;
      if (rx_push) begin
        rx_mem[rx_wr] <= rx_data;
        rx_wr <= rx_wr + 1'b1;
      end
    end
  end

  spi_slave_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .cpha_i(cpha), .lsb_first_i(lsb),
    .tx_en_i(tx_en), .rx_en_i(rx_en), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_pop_o(tx_pop), .rx_data_o(rx_data), .rx_push_o(rx_push), .rx_space_i(rx_space),
    .underflow_o(ufl), .overflow_o(ofl), .clr_underflow_i(clr_u), .clr_overflow_i(clr_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] h_mo [4];
  logic [7:0] h_mi [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_tx(input logic [7:0] b);
    tx_mem[tx_wr] = b;
    tx_wr = tx_wr + 1'b1;
  endtask

  task automatic set_mode(input logic p, input logic ph, input logic l);
    cpol = p; cpha = ph; lsb = l; sck = p;
    wclk(4);
  endtask

  task automatic xfer_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      int k;
      k = lsb ? i : 7 - i;
      if (!cpha) begin
        mosi = mo[k];
        wclk(H);
        mi[k] = miso;
        sck = ~cpol;
        wclk(H);
        sck = cpol;
      end else begin
        sck = ~cpol;
        mosi = mo[k];
        wclk(H);
        mi[k] = miso;
        sck = cpol;
        wclk(H);
      end
    end
  endtask

  task automatic frame(input int n);
    csn = 1'b0;
    wclk(H);
    for (int b = 0; b < n; b++) xfer_bits(h_mo[b], 8, h_mi[b]);
    wclk(H);
    csn = 1'b1;
    wclk(2 * H);
  endtask

  task automatic clear_flags();
    clr_u = 1; clr_o = 1;
    wclk(1);
    clr_u = 0; clr_o = 0;
    wclk(1);
  endtask

  task automatic test_reset();
    chk(ufl == 0, "R6", "underflow after reset", 32'(ufl), 0);
    chk(ofl == 0, "R6", "overflow after reset", 32'(ofl), 0);
    chk(miso_oe == 0, "R9", "oe after reset", 32'(miso_oe), 0);
    chk(tx_pop == 0 && rx_push == 0, "R1", "no handshake after reset",
        32'({tx_pop, rx_push}), 0);
  endtask

  task automatic test_modes();
    for (int m = 0; m < 8; m++) begin
      logic [7:0] t0, t1;
      logic [5:0] rbase;
      t0 = 8'hC3 + 8'(m * 17);
      t1 = 8'h1E ^ 8'(m * 40);
      h_mo[0] = 8'h96 + 8'(m);
      h_mo[1] = 8'h4D - 8'(m * 3);
      set_mode(m[0], m[1], m[2]);
      push_tx(t0); push_tx(t1);
      rbase = rx_wr;
      frame(2);
      chk(h_mi[0] == t0, "R5", "miso byte0", 32'(h_mi[0]), 32'(t0));
      chk(h_mi[1] == t1, "R1", "miso byte1", 32'(h_mi[1]), 32'(t1));
      chk(rx_wr == rbase + 6'd2, "R3", "push count", 32'(rx_wr - rbase), 2);
      chk(rx_mem[rbase] == h_mo[0], "R5", "rx byte0", 32'(rx_mem[rbase]), 32'(h_mo[0]));
      chk(rx_mem[rbase + 6'd1] == h_mo[1], "R3", "rx byte1",
          32'(rx_mem[rbase + 6'd1]), 32'(h_mo[1]));
      chk(tx_rd == tx_wr && ufl == 0 && ofl == 0, "R1", "fifo drained, no errors",
          32'({ufl, ofl, tx_wr - tx_rd}), 0);
    end
  endtask

  task automatic test_underflow();
    set_mode(0, 0, 0);
    push_tx(8'h81);
    h_mo[0] = 8'h11; h_mo[1] = 8'h22;
    frame(2);
    chk(h_mi[0] == 8'h81, "R1", "data before underflow", 32'(h_mi[0]), 32'h81);
    chk(h_mi[1] == 8'hFF, "R2", "underflow byte is ones", 32'(h_mi[1]), 32'hFF);
    chk(ufl == 1, "R2", "underflow flag", 32'(ufl), 1);
    wclk(5);
    chk(ufl == 1, "R6", "underflow sticky", 32'(ufl), 1);
    clear_flags();
    chk(ufl == 0, "R6", "underflow cleared", 32'(ufl), 0);
    set_mode(1, 1, 1);
    h_mo[0] = 8'h33;
    frame(1);
    chk(h_mi[0] == 8'hFF && ufl == 1, "R2", "phase1 underflow",
        32'({ufl, h_mi[0]}), 32'h1FF);
    clear_flags();
  endtask

  task automatic test_tx_disabled();
    logic [5:0] rd0;
    set_mode(0, 1, 0);
    tx_en = 0;
    push_tx(8'hA5);
    rd0 = tx_rd;
    h_mo[0] = 8'h5C;
    frame(1);
    chk(h_mi[0] == 8'hFF, "R1", "disabled tx sends ones", 32'(h_mi[0]), 32'hFF);
    chk(tx_rd == rd0, "R1", "disabled tx no pop", 32'(tx_rd - rd0), 0);
    chk(ufl == 0, "R2", "disabled tx no underflow", 32'(ufl), 0);
    tx_en = 1;
    frame(1);
    chk(h_mi[0] == 8'hA5, "R1", "queued byte sent after enable", 32'(h_mi[0]), 32'hA5);
  endtask

  task automatic test_overflow();
    logic [5:0] r0;
    set_mode(0, 0, 1);
    tx_en = 0;
    rx_space = 0;
    r0 = rx_wr;
    h_mo[0] = 8'h7E;
    frame(1);
    chk(rx_wr == r0, "R4", "no push when full", 32'(rx_wr - r0), 0);
    chk(ofl == 1, "R4", "overflow flag", 32'(ofl), 1);
    clear_flags();
    chk(ofl == 0, "R6", "overflow cleared", 32'(ofl), 0);
    rx_en = 0;
    frame(1);
    chk(ofl == 0 && rx_wr == r0, "R3", "rx disabled and full: silent",
        32'({ofl, rx_wr - r0}), 0);
    rx_space = 1;
    frame(1);
    chk(rx_wr == r0, "R3", "rx disabled: no push", 32'(rx_wr - r0), 0);
    rx_en = 1;
    tx_en = 1;
  endtask

  task automatic test_abort();
    logic [5:0] r0, t0;
    logic [7:0] junk;
    set_mode(0, 0, 0);
    push_tx(8'h5A); push_tx(8'hE7);
    r0 = rx_wr; t0 = tx_rd;
    csn = 0;
    wclk(H);
    xfer_bits(8'hF0, 4, junk);
    csn = 1;
    wclk(2 * H);
    chk(rx_wr == r0, "R7", "aborted byte not pushed", 32'(rx_wr - r0), 0);
    chk(tx_rd == t0 + 6'd1, "R1", "aborted byte popped once", 32'(tx_rd - t0), 1);
    h_mo[0] = 8'h3C;
    frame(1);
    chk(rx_mem[r0] == 8'h3C, "R7", "fresh byte after abort", 32'(rx_mem[r0]), 32'h3C);
    chk(h_mi[0] == 8'hE7, "R7", "next tx byte after abort", 32'(h_mi[0]), 32'hE7);
  endtask

  task automatic test_empty_select();
    for (int ph = 0; ph < 2; ph++) begin
      logic [5:0] t0;
      set_mode(0, ph[0], 0);
      if (ph == 0) push_tx(8'h99);
      t0 = tx_rd;
      frame(0);
      chk(tx_rd == t0 && ufl == 0, "R8", "select without clocks pops nothing",
          32'({ufl, tx_rd - t0}), 0);
    end
    frame(1);
    chk(h_mi[0] == 8'h99, "R8", "byte kept for later frame", 32'(h_mi[0]), 32'h99);
  endtask

  task automatic test_oe();
    set_mode(0, 0, 0);
    csn = 0;
    wclk(4);
    chk(miso_oe == 1, "R9", "oe while selected", 32'(miso_oe), 1);
    csn = 1;
    wclk(4);
    chk(miso_oe == 0, "R9", "oe after deselect", 32'(miso_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    test_reset();
    test_modes();
    test_underflow();
    test_tx_disabled();
    test_overflow();
    test_abort();
    test_empty_select();
    test_oe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule